// File: doc/BRIEF.md
# Audio Frame Sequencer with Frame Interrupt

This block sets the pace for the slow-rate units of a sound generator. A clock enable that pulses once per CPU cycle drives a step counter. At fixed counts the counter emits a quarter-frame strobe, which envelope and linear-counter logic consume, and a half-frame strobe, which length-counter and sweep logic consume. In the shorter of its two sequences it also raises a frame interrupt at the end of each pass. Software selects the sequence and masks the interrupt by writing a mode byte. It reads a status byte that reports the frame flag and an externally supplied sample-channel interrupt. A status read acknowledges the frame flag.

A mode write does not act at once. The new settings wait in a holding register until a short delay has run out. The length of that delay depends on whether the write came on an even or an odd CPU cycle. When the delay ends, the settings take effect together and the step counter restarts. If the longer sequence was chosen, both strobes fire on that same cycle. Every pin is a plain control or status signal. Nothing streams through the block, so no valid/ready handshake is needed.

Top module: `frame_seq`

## Requirements
- R1: During and right after reset, `qtr_tick`, `half_tick` and `irq` are low and `stat_rdata` is 0. The block starts in the four-step sequence with the frame interrupt allowed, and the parity bit starts even.
- R2: In the four-step sequence, counting enables from a restart, `qtr_tick` pulses after enables 7457, 14913, 22371 and 29829. `half_tick` pulses only after 14913 and 29829. The count wraps after enable 29830, so the pattern repeats every 29830 enables.
- R3: Each strobe is high for one clock, in the clock that follows the enable edge that completed the step. While `cpu_ce` is low the count does not advance.
- R4: In the four-step sequence with the interrupt allowed, the frame flag is set on enable 29829 after a restart and stays set until it is cleared.
- R5: `stat_rdata` carries the frame flag in bit 6, `ext_irq` in bit 7, and zeros in bits 5..0. A clock with `stat_rd` high returns the current flag and clears it at that clock edge.
- R6: A mode write (`mode_wr`) takes bit 7 as the five-step select and bit 6 as the interrupt mask and holds both as pending. A parity bit toggles on every enable. If parity is even at the write, the pending values take effect on the 3rd enable after the write edge. If parity is odd, they take effect on the 4th. At that edge the step count returns to zero.
- R7: A mode write with bit 6 set clears the frame flag at the write edge. After it takes effect, no new flag is raised.
- R8: When the five-step sequence takes effect, `qtr_tick` and `half_tick` both pulse on that enable. From there, quarter steps fall at 7457, 14913, 22371 and 37281. Half steps fall at 14913 and 37281. There is no strobe at 29829, the count wraps after 37282, and the frame flag is never set.
- R9: `irq` is high whenever the frame flag is set or `ext_irq` is high. A status read does not clear the `ext_irq` contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | One pulse per CPU cycle; advances counter and parity |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte: bit 7 five-step, bit 6 interrupt mask |
| stat_rd | input | 1 | Status read strobe; acknowledges the frame flag |
| ext_irq | input | 1 | Interrupt from the sample channel |
| stat_rdata | output | 8 | Status byte: bit 7 ext_irq, bit 6 frame flag |
| qtr_tick | output | 1 | Quarter-frame strobe |
| half_tick | output | 1 | Half-frame strobe |
| irq | output | 1 | Combined interrupt line |

## Verification
A step counter that is off by even one count moves every later strobe by that amount. That error holds for the rest of the run. The first strobe after a restart already shows it, 7457 enables in, and the scoreboard compares every strobe against its exact enable number. A parity bit that is flipped changes the delay between a write and its effect by one enable. The result is a shifted schedule, or a missing or early combined strobe just after a five-step write, visible within four enables. A flag that clears or sets wrongly shows on `irq` and status bit 6 on the next clock, and both are checked one enable on either side of each expected change.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int unsigned STEP_A   = 7457;
  localparam int unsigned STEP_B   = 14913;
  localparam int unsigned STEP_C   = 22371;
  localparam int unsigned STEP_D   = 29829;
  localparam int unsigned STEP_E   = 37281;
  localparam int unsigned LAG_EVEN = 3;
  localparam int unsigned LAG_ODD  = 4;
  localparam int unsigned SEL_BIT  = 7;
  localparam int unsigned MASK_BIT = 6;

  typedef struct packed {
    logic five;
    logic mask;
  } seq_mode_t;
endpackage

// File: rtl/fseq_ctl.sv
module fseq_ctl
  import fseq_pkg::*;
#(
  parameter int unsigned LAG_E = LAG_EVEN,
  parameter int unsigned LAG_O = LAG_ODD
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce,
  input  logic      wr,
  input  seq_mode_t wval,
  output seq_mode_t cur,
  output logic      pend_five,
  output logic      commit
);
  localparam int unsigned DW = $clog2(LAG_O + 1);

  logic          par;
  logic [DW-1:0] lag;
  seq_mode_t     pend;

  assign commit    = ce && !wr && (lag == DW'(1));
  assign pend_five = pend.five;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par  <= 1'b0;
      lag  <= '0;
      pend <= '0;
      cur  <= '0;
    end else begin
      if (ce) par <= ~par;
      if (wr) begin
        pend <= wval;
        lag  <= par ? DW'(LAG_O) : DW'(LAG_E);
      end else if (ce && lag != '0) begin
        lag <= lag - DW'(1);
        if (lag == DW'(1)) cur <= pend;
      end
    end
  end

  // R6: the delay never exceeds the longer setting
  p_lag_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lag <= DW'(LAG_O));
  // R6: the active mode changes only on a commit edge
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cur));
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
  import fseq_pkg::*;
#(
  parameter int unsigned S1 = STEP_A,
  parameter int unsigned S2 = STEP_B,
  parameter int unsigned S3 = STEP_C,
  parameter int unsigned S4 = STEP_D,
  parameter int unsigned S5 = STEP_E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic five,
  input  logic commit,
  input  logic commit_five,
  output logic qtr,
  output logic half,
  output logic frame_hit
);
  localparam int unsigned WRAP4 = S4 + 1;
  localparam int unsigned WRAP5 = S5 + 1;
  localparam int unsigned CW    = $clog2(WRAP5 + 1);

  logic [CW-1:0] cnt, nx;
  logic          hit_q, hit_h, last;

  always_comb begin
    nx    = cnt + CW'(1);
    hit_q = (nx == CW'(S1)) || (nx == CW'(S2)) || (nx == CW'(S3)) ||
            (!five && nx == CW'(S4)) || (five && nx == CW'(S5));
    hit_h = (nx == CW'(S2)) ||
            (!five && nx == CW'(S4)) || (five && nx == CW'(S5));
    last  = five ? (nx == CW'(WRAP5)) : (nx == CW'(WRAP4));
  end

  assign frame_hit = ce && !commit && !five && (nx == CW'(S4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      qtr  <= 1'b0;
      half <= 1'b0;
    end else begin
      qtr  <= 1'b0;
      half <= 1'b0;
      if (ce) begin
        if (commit) begin
          cnt  <= '0;
          qtr  <= commit_five;
          half <= commit_five;
        end else begin
          cnt  <= last ? '0 : nx;
          qtr  <= hit_q;
          half <= hit_h;
        end
      end
    end
  end

  // R2: a half step is always also a quarter step
  p_half_with_qtr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> qtr);
  // R3: no counting without an enable
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(cnt));
  // R6: a commit restarts the count
  p_commit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cnt == '0);
  // R8: count stays below the longest period
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(WRAP5));
endmodule

// File: rtl/fseq_irq.sv
module fseq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic mask,
  input  logic five,
  input  logic mask_wr,
  input  logic rd,
  output logic flag
);
  logic set;
  assign set = hit && !mask;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (mask_wr) flag <= 1'b0;
    else if (set)     flag <= 1'b1;
    else if (rd)      flag <= 1'b0;
  end

  // R7: a masking write drops the flag
  p_mask_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> !flag);
  // R5: a read with no coincident set acknowledges
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> !flag);
  // R8: the five-step sequence never raises the flag
  p_no_rise_five_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(five));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import fseq_pkg::*;
#(
  parameter int unsigned S1    = STEP_A,
  parameter int unsigned S2    = STEP_B,
  parameter int unsigned S3    = STEP_C,
  parameter int unsigned S4    = STEP_D,
  parameter int unsigned S5    = STEP_E,
  parameter int unsigned LAG_E = LAG_EVEN,
  parameter int unsigned LAG_O = LAG_ODD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_ce,
  input  logic       mode_wr,
  input  logic [7:0] mode_wdata,
  input  logic       stat_rd,
  input  logic       ext_irq,
  output logic [7:0] stat_rdata,
  output logic       qtr_tick,
  output logic       half_tick,
  output logic       irq
);
  seq_mode_t wval, cur;
  logic      pend_five, commit, frame_hit, flag, mask_wr;
  logic      wdata_unused;

  assign wval.five    = mode_wdata[SEL_BIT];
  assign wval.mask    = mode_wdata[MASK_BIT];
  assign wdata_unused = ^mode_wdata[5:0];
  assign mask_wr      = mode_wr && mode_wdata[MASK_BIT];

  fseq_ctl #(.LAG_E(LAG_E), .LAG_O(LAG_O)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ce(cpu_ce), .wr(mode_wr), .wval(wval),
    .cur(cur), .pend_five(pend_five), .commit(commit)
  );

  fseq_timer #(.S1(S1), .S2(S2), .S3(S3), .S4(S4), .S5(S5)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ce(cpu_ce), .five(cur.five),
    .commit(commit), .commit_five(pend_five),
    .qtr(qtr_tick), .half(half_tick), .frame_hit(frame_hit)
  );

  fseq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .hit(frame_hit), .mask(cur.mask),
    .five(cur.five), .mask_wr(mask_wr), .rd(stat_rd), .flag(flag)
  );

  assign stat_rdata = {ext_irq, flag, 6'b0};
  assign irq        = flag | ext_irq;
endmodule

// File: tb/sim_frame_seq.sv
module sim_frame_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_ce = 1'b1;
  logic       mode_wr = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic       stat_rd = 1'b0;
  logic       ext_irq = 1'b0;
  logic [7:0] stat_rdata;
  logic       qtr_tick, half_tick, irq;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  bit done   = 0;

  typedef struct {
    int         at;
    logic [1:0] kind;
  } ev_t;
  ev_t expq[$];

  frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .stat_rd(stat_rd), .ext_irq(ext_irq),
    .stat_rdata(stat_rdata), .qtr_tick(qtr_tick), .half_tick(half_tick),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n && cpu_ce) ncyc <= ncyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int at, input logic [1:0] kind);
    ev_t e;
    e.at = at; e.kind = kind;
    expq.push_back(e);
  endtask

  task automatic wait_ce(input int n);
    while (ncyc < n) @(negedge clk);
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0; mode_wdata = 8'h00;
  endtask

  task automatic read_status(output logic [7:0] v);
    stat_rd = 1'b1;
    #1 v = stat_rdata;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  // Monitor: every strobe observed is matched against the expected queue (R2 R3 R8)
  always @(negedge clk) begin
    if (rst_n && (qtr_tick || half_tick)) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R2/R8 unexpected strobe actual=%0d/%b expected=none",
                 ncyc, {half_tick, qtr_tick});
      end else begin
        ev_t e;
        e = expq.pop_front();
        if (e.at != ncyc || e.kind != {half_tick, qtr_tick}) begin
          fails++;
          $display("FAIL R2/R8/R3 strobe actual=%0d/%b expected=%0d/%b",
                   ncyc, {half_tick, qtr_tick}, e.at, e.kind);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", ncyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 qtr in reset", qtr_tick, 0);
    check("R1 half in reset", half_tick, 0);
    check("R1 irq in reset", irq, 0);
    check("R1 status in reset", stat_rdata, 0);
    rst_n = 1'b1;

    // four-step frames after reset (R2)
    push(7457, 2'b01);  push(14913, 2'b11); push(22371, 2'b01); push(29829, 2'b11);
    push(37287, 2'b01); push(44743, 2'b11); push(52201, 2'b01); push(59659, 2'b11);

    wait_ce(29828);
    check("R4 irq before last step", irq, 0);
    wait_ce(29829);
    check("R4 irq on last step", irq, 1);
    check("R5 status shows flag", stat_rdata, 8'h40);

    wait_ce(29840);
    read_status(v);
    check("R5 read value", v, 8'h40);
    check("R5 irq after read", irq, 0);
    check("R5 status after read", stat_rdata, 0);

    wait_ce(30000);
    ext_irq = 1'b1;
    #1 check("R9 irq from ext", irq, 1);
    check("R9 status bit7", stat_rdata, 8'h80);
    read_status(v);
    check("R9 ext survives read", irq, 1);
    ext_irq = 1'b0;
    #1 check("R9 irq drops", irq, 0);

    // R3: gate the enable; schedule above is in enable units
    wait_ce(31000);
    cpu_ce = 1'b0;
    repeat (50) @(negedge clk);
    check("R3 no strobe while gated", qtr_tick | half_tick, 0);
    cpu_ce = 1'b1;

    wait_ce(59659);
    check("R4 second frame flag", irq, 1);

    // R7: masking write at even parity, commit at 59674
    wait_ce(59670);
    push(67131, 2'b01); push(74587, 2'b11); push(82045, 2'b01); push(89503, 2'b11);
    write_mode(8'h40);
    check("R7 mask write clears flag", irq, 0);
    wait_ce(89503);
    check("R7 masked frame has no irq", irq, 0);

    // R6/R8: five-step write at odd parity, commit at 89516
    wait_ce(89511);
    push(89516, 2'b11);  push(96973, 2'b01); push(104429, 2'b11);
    push(111887, 2'b01); push(126797, 2'b11); push(134255, 2'b01);
    write_mode(8'h80);
    wait_ce(89515);
    check("R6 odd delay not yet done", qtr_tick, 0);
    wait_ce(89516);
    check("R8 immediate combined strobe", qtr_tick & half_tick, 1);
    wait_ce(126800);
    check("R8 no flag in five-step", irq, 0);
    check("R8 status clear", stat_rdata, 0);

    // R6: back to four-step at even parity, commit at 134304
    wait_ce(134300);
    push(141761, 2'b01); push(149217, 2'b11); push(156675, 2'b01); push(164133, 2'b11);
    write_mode(8'h00);
    wait_ce(164132);
    check("R6 flag not early after restart", irq, 0);
    wait_ce(164133);
    check("R6 flag after even delay restart", irq, 1);

    wait_ce(164200);
    while (expq.size() != 0) begin
      ev_t e;
      e = expq.pop_front();
      checks++; fails++;
      $display("FAIL R2/R8 missing strobe actual=none expected=%0d/%b", e.at, e.kind);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule